// File: doc/BRIEF.md
# Panel Timing Generator with Pixel Clock Divider

This block drives the timing side of a parallel RGB panel. From a set of programmable fields it produces horizontal sync, vertical sync, a data-enable, a pixel-rate strobe, a pixel clock level and the current column and row inside the visible area. The pixel rate comes from the system clock in one of two ways. A programmable integer divider can set it, or a bypass can make every system cycle a pixel.

Each timing field is loaded with a count less one, except the vertical back porch, which holds its real line count and may be zero. The divider field holds the ratio less two, so the smallest ratio is two. Software works out the ratio as the system clock over the wanted pixel clock, rounded up. A line runs through sync, back porch, visible pixels and front porch, in that order. A frame runs through the same four regions, counted in whole lines. Fields may be rewritten at any time. The block takes a new set of fields into use only at a frame boundary, or while it is disabled.

A format field tells the downstream data path how many bus lanes carry colour. The block turns it into a lane mask. Fetching pixels and converting colours belong to other blocks.

Top module: `panel_timing_gen`

## Requirements
- R1: While `enable` is low, `pixStrobe`, `pclkOut`, `de`, `pixX` and `pixY` are all 0, and each sync output rests at its inactive level, which equals its polarity bit.
- R2: With `cfgBypass` = 0 the ratio N is `cfgDiv`+2. `pixStrobe` fires once every N system cycles, and `pclkOut` is high for ceil(N/2) of every N cycles.
- R3: With `cfgBypass` = 1 the divider field has no effect: `pixStrobe` is high on every enabled cycle and `pclkOut` stays high.
- R4: In divided mode with `cfgClkFall` = 0, the strobe falls on the first cycle in which `pclkOut` is high. With `cfgClkFall` = 1 it falls on the first cycle in which `pclkOut` is low.
- R5: Counted in strobes, each line is hsync (`cfgHSync`+1), then back porch (`cfgHBack`+1), then visible (`cfgWidth`+1), then front porch (`cfgHFront`+1).
- R6: The vertical position advances once per completed line. A frame is vsync (`cfgVSync`+1 lines), then back porch (`cfgVBack` lines, none when 0), then visible (`cfgHeight`+1), then front porch (`cfgVFront`+1).
- R7: `de` is high exactly when both the line and the frame are in their visible regions. There `pixX` and `pixY` count from 0, and outside it both are 0.
- R8: A polarity bit of 1 makes the matching sync pulse active-low. A bit of 0 makes it active-high.
- R9: `busMask` has its low 12, 16, 18 or 24 bits set for `cfgFmt` 0, 1, 2 or 3.
- R10: Fields written during a frame, the divider included, leave the rest of that frame unchanged. They apply from the first pixel of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous-free synchronous reset |
| enable | input | 1 | Run the timing; low holds the block idle |
| cfgHSync | input | SYNC_W | Hsync width minus one |
| cfgHBack | input | PORCH_W | Horizontal back porch minus one |
| cfgWidth | input | ACT_W | Visible width minus one |
| cfgHFront | input | PORCH_W | Horizontal front porch minus one |
| cfgVSync | input | SYNC_W | Vsync lines minus one |
| cfgVBack | input | PORCH_W | Vertical back porch lines, not offset |
| cfgHeight | input | ACT_W | Visible height minus one |
| cfgVFront | input | PORCH_W | Vertical front porch lines minus one |
| cfgHSyncLow | input | 1 | Hsync active-low when 1 |
| cfgVSyncLow | input | 1 | Vsync active-low when 1 |
| cfgFmt | input | 2 | Bus format: 0=12, 1=16, 2=18, 3=24 bits |
| cfgDiv | input | DIV_W | Divide ratio minus two |
| cfgBypass | input | 1 | Use the system clock as the pixel clock |
| cfgClkFall | input | 1 | Data changes on the falling pixel clock edge |
| pixStrobe | output | 1 | One-cycle pixel enable |
| pclkOut | output | 1 | Pixel clock level (held high in bypass) |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pixX | output | ACT_W | Column inside the visible area |
| pixY | output | ACT_W | Row inside the visible area |
| busMask | output | 24 | Lanes carrying colour data |

## Verification
Suppose a phase counter slips by one. The next strobe then shows a sync or `de` edge one pixel early or late, and every later pixel of that line or frame keeps the offset. A mistake in vertical counting appears at the next line boundary, no later. A divider fault shows within one pixel period as a wrong gap between strobes or a wrong high time. A shadow register that loads at the wrong moment shows on the first pixel after the mid-frame write. Comparing every strobe against an arithmetic model of the position therefore finds each of these faults within one line.

// File: rtl/panel_timing_pkg.sv
package panel_timing_pkg;

  localparam int BUS_W = 24;

  typedef enum logic [1:0] {
    PH_SYNC  = 2'd0,
    PH_BACK  = 2'd1,
    PH_ACT   = 2'd2,
    PH_FRONT = 2'd3
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic tick;   // advance one pixel
    logic clear;  // idle: hold counters at frame origin
    logic load;   // capture live fields into shadows
  } ctrl_s;

endpackage

// File: rtl/ptg_control.sv
module ptg_control
  import panel_timing_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [DIV_W-1:0] cfgDiv,
  input  logic             cfgBypass,
  input  logic             cfgClkFall,
  input  logic             lastPix,
  output ctrl_s            ctrl,
  output logic             pclkOut
);

  localparam int NW = DIV_W + 1;

  logic             run;
  logic [NW-1:0]    divCnt;
  logic [DIV_W-1:0] shDiv;
  logic             shBypass;
  logic             shClkFall;

  logic [NW-1:0] ratio, hiCnt, edgeIdx;
  logic [NW-1:0] newRatio, newHi, newEdge, wrapCnt;
  logic          tick, load, frameWrap;

  always_comb begin
    ratio   = NW'({1'b0, shDiv}) + NW'(2);
    hiCnt   = (ratio + NW'(1)) >> 1;
    edgeIdx = shClkFall ? hiCnt : '0;

    newRatio = NW'({1'b0, cfgDiv}) + NW'(2);
    newHi    = (newRatio + NW'(1)) >> 1;
    newEdge  = cfgClkFall ? newHi : '0;
    wrapCnt  = (newEdge == newRatio - NW'(1)) ? '0 : newEdge + NW'(1);
  end

  assign tick      = run && (shBypass || (divCnt == edgeIdx));
  assign frameWrap = tick && lastPix;
  assign load      = !run || frameWrap;

  assign ctrl.tick  = tick;
  assign ctrl.clear = !run;
  assign ctrl.load  = load;

  assign pclkOut = run && (shBypass || (divCnt < hiCnt));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      run       <= 1'b0;
      divCnt    <= '0;
      shDiv     <= '0;
      shBypass  <= 1'b0;
      shClkFall <= 1'b0;
    end else begin
      run <= enable;
      if (load) begin
        shDiv     <= cfgDiv;
        shBypass  <= cfgBypass;
        shClkFall <= cfgClkFall;
      end
      if (!run) begin
        divCnt <= '0;
      end else if (frameWrap) begin
        // reseed so the next strobe lands one full new period later
        divCnt <= wrapCnt;
      end else if (divCnt >= ratio - NW'(1)) begin
        divCnt <= '0;
      end else begin
        divCnt <= divCnt + NW'(1);
      end
    end
  end

  // R2
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !shBypass) |=> (!tick || shBypass));

  // R4
  rise_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (run && $past(run) && !$past(load) && !shBypass && !shClkFall && $rose(pclkOut))
      |-> tick);

  // R4
  fall_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (run && $past(run) && !$past(load) && !shBypass && shClkFall && $fell(pclkOut))
      |-> tick);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !run |-> (!tick && !pclkOut));

endmodule

// File: rtl/ptg_datapath.sv
module ptg_datapath
  import panel_timing_pkg::*;
#(
  parameter int SYNC_W  = 6,
  parameter int PORCH_W = 8,
  parameter int ACT_W   = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrl_s              ctrl,
  input  logic [SYNC_W-1:0]  cfgHSync,
  input  logic [PORCH_W-1:0] cfgHBack,
  input  logic [ACT_W-1:0]   cfgWidth,
  input  logic [PORCH_W-1:0] cfgHFront,
  input  logic [SYNC_W-1:0]  cfgVSync,
  input  logic [PORCH_W-1:0] cfgVBack,
  input  logic [ACT_W-1:0]   cfgHeight,
  input  logic [PORCH_W-1:0] cfgVFront,
  input  logic               cfgHSyncLow,
  input  logic               cfgVSyncLow,
  input  logic [1:0]         cfgFmt,
  output logic               hsync,
  output logic               vsync,
  output logic               de,
  output logic [ACT_W-1:0]   pixX,
  output logic [ACT_W-1:0]   pixY,
  output logic [BUS_W-1:0]   busMask,
  output logic               lastPix
);

  localparam int WIDE_A = (ACT_W > PORCH_W) ? ACT_W : PORCH_W;
  localparam int CNT_W  = (WIDE_A > SYNC_W) ? WIDE_A : SYNC_W;

  logic [SYNC_W-1:0]  shHSync, shVSync;
  logic [PORCH_W-1:0] shHBack, shHFront, shVBack, shVFront;
  logic [ACT_W-1:0]   shWidth, shHeight;
  logic               shHLow, shVLow;
  logic [1:0]         shFmt;

  phase_e           hPh, vPh, hNext, vNext;
  logic [CNT_W-1:0] hCnt, vCnt, hLast, vLast;
  logic             hEnd, vEnd, lineEnd, running, inAct;

  always_comb begin
    unique case (hPh)
      PH_SYNC:  begin hLast = CNT_W'(shHSync);  hNext = PH_BACK;  end
      PH_BACK:  begin hLast = CNT_W'(shHBack);  hNext = PH_ACT;   end
      PH_ACT:   begin hLast = CNT_W'(shWidth);  hNext = PH_FRONT; end
      default:  begin hLast = CNT_W'(shHFront); hNext = PH_SYNC;  end
    endcase
    unique case (vPh)
      PH_SYNC: begin
        vLast = CNT_W'(shVSync);
        vNext = (shVBack == '0) ? PH_ACT : PH_BACK;
      end
      PH_BACK:  begin vLast = CNT_W'(shVBack) - CNT_W'(1); vNext = PH_ACT;   end
      PH_ACT:   begin vLast = CNT_W'(shHeight);            vNext = PH_FRONT; end
      default:  begin vLast = CNT_W'(shVFront);            vNext = PH_SYNC;  end
    endcase
  end

  assign hEnd    = (hCnt == hLast);
  assign vEnd    = (vCnt == vLast);
  assign lineEnd = hEnd && (hPh == PH_FRONT);
  assign lastPix = lineEnd && vEnd && (vPh == PH_FRONT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hPh <= PH_SYNC;  hCnt <= '0;
      vPh <= PH_SYNC;  vCnt <= '0;
      shHSync <= '0; shHBack <= '0; shWidth  <= '0; shHFront <= '0;
      shVSync <= '0; shVBack <= '0; shHeight <= '0; shVFront <= '0;
      shHLow  <= 1'b0; shVLow <= 1'b0; shFmt <= '0;
    end else begin
      if (ctrl.load) begin
        shHSync <= cfgHSync; shHBack <= cfgHBack; shWidth  <= cfgWidth;  shHFront <= cfgHFront;
        shVSync <= cfgVSync; shVBack <= cfgVBack; shHeight <= cfgHeight; shVFront <= cfgVFront;
        shHLow  <= cfgHSyncLow; shVLow <= cfgVSyncLow; shFmt <= cfgFmt;
      end
      if (ctrl.clear) begin
        hPh <= PH_SYNC;  hCnt <= '0;
        vPh <= PH_SYNC;  vCnt <= '0;
      end else if (ctrl.tick) begin
        if (hEnd) begin
          hCnt <= '0;
          hPh  <= hNext;
        end else begin
          hCnt <= hCnt + CNT_W'(1);
        end
        if (lineEnd) begin
          if (vEnd) begin
            vCnt <= '0;
            vPh  <= vNext;
          end else begin
            vCnt <= vCnt + CNT_W'(1);
          end
        end
      end
    end
  end

  assign running = !ctrl.clear;
  assign inAct   = (hPh == PH_ACT) && (vPh == PH_ACT);
  assign de      = running && inAct;
  assign pixX    = de ? ACT_W'(hCnt) : '0;
  assign pixY    = de ? ACT_W'(vCnt) : '0;
  assign hsync   = (running && (hPh == PH_SYNC)) ^ shHLow;
  assign vsync   = (running && (vPh == PH_SYNC)) ^ shVLow;

  always_comb begin
    unique case (shFmt)
      2'd0:    busMask = BUS_W'(24'h000FFF);
      2'd1:    busMask = BUS_W'(24'h00FFFF);
      2'd2:    busMask = BUS_W'(24'h03FFFF);
      default: busMask = BUS_W'(24'hFFFFFF);
    endcase
  end

  // R7
  de_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(de) |-> (pixX == '0));

  // R7
  x_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (de && ctrl.tick && !hEnd) |=>
      (ctrl.clear || (de && (pixX == ACT_W'($past(pixX) + 1'b1)))));

  // R6
  v_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.clear && !(ctrl.tick && lineEnd)) |=> ($stable(vCnt) && $stable(vPh)));

  // R10
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.load |=> $stable({shHSync, shHBack, shWidth, shHFront, shVSync,
                            shVBack, shHeight, shVFront, shHLow, shVLow, shFmt}));

  // R9
  mask_floor_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busMask[11:0] == 12'hFFF) && ($countones(busMask) >= 12));

endmodule

// File: rtl/panel_timing_gen.sv
module panel_timing_gen
  import panel_timing_pkg::*;
#(
  parameter int SYNC_W  = 6,
  parameter int PORCH_W = 8,
  parameter int ACT_W   = 10,
  parameter int DIV_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic [SYNC_W-1:0]  cfgHSync,
  input  logic [PORCH_W-1:0] cfgHBack,
  input  logic [ACT_W-1:0]   cfgWidth,
  input  logic [PORCH_W-1:0] cfgHFront,
  input  logic [SYNC_W-1:0]  cfgVSync,
  input  logic [PORCH_W-1:0] cfgVBack,
  input  logic [ACT_W-1:0]   cfgHeight,
  input  logic [PORCH_W-1:0] cfgVFront,
  input  logic               cfgHSyncLow,
  input  logic               cfgVSyncLow,
  input  logic [1:0]         cfgFmt,
  input  logic [DIV_W-1:0]   cfgDiv,
  input  logic               cfgBypass,
  input  logic               cfgClkFall,
  output logic               pixStrobe,
  output logic               pclkOut,
  output logic               hsync,
  output logic               vsync,
  output logic               de,
  output logic [ACT_W-1:0]   pixX,
  output logic [ACT_W-1:0]   pixY,
  output logic [23:0]        busMask
);

  ctrl_s ctrl;
  logic  lastPix;

  ptg_control #(.DIV_W(DIV_W)) u_control (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .cfgDiv     (cfgDiv),
    .cfgBypass  (cfgBypass),
    .cfgClkFall (cfgClkFall),
    .lastPix    (lastPix),
    .ctrl       (ctrl),
    .pclkOut    (pclkOut)
  );

  ptg_datapath #(
    .SYNC_W  (SYNC_W),
    .PORCH_W (PORCH_W),
    .ACT_W   (ACT_W)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .cfgHSync    (cfgHSync),
    .cfgHBack    (cfgHBack),
    .cfgWidth    (cfgWidth),
    .cfgHFront   (cfgHFront),
    .cfgVSync    (cfgVSync),
    .cfgVBack    (cfgVBack),
    .cfgHeight   (cfgHeight),
    .cfgVFront   (cfgVFront),
    .cfgHSyncLow (cfgHSyncLow),
    .cfgVSyncLow (cfgVSyncLow),
    .cfgFmt      (cfgFmt),
    .hsync       (hsync),
    .vsync       (vsync),
    .de          (de),
    .pixX        (pixX),
    .pixY        (pixY),
    .busMask     (busMask),
    .lastPix     (lastPix)
  );

  assign pixStrobe = ctrl.tick;

endmodule

// File: tb/panel_timing_gen_tb.sv
module panel_timing_gen_tb;

  localparam int SYNC_W = 6, PORCH_W = 8, ACT_W = 10, DIV_W = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, enable;
  logic [SYNC_W-1:0]  cfgHSync, cfgVSync;
  logic [PORCH_W-1:0] cfgHBack, cfgHFront, cfgVBack, cfgVFront;
  logic [ACT_W-1:0]   cfgWidth, cfgHeight;
  logic cfgHSyncLow, cfgVSyncLow, cfgBypass, cfgClkFall;
  logic [1:0] cfgFmt;
  logic [DIV_W-1:0] cfgDiv;
  logic pixStrobe, pclkOut, hsync, vsync, de;
  logic [ACT_W-1:0] pixX, pixY;
  logic [23:0] busMask;

  panel_timing_gen #(.SYNC_W(SYNC_W), .PORCH_W(PORCH_W), .ACT_W(ACT_W), .DIV_W(DIV_W)) u_dut (
    .clk(clk), .rstN(rstN), .enable(enable),
    .cfgHSync(cfgHSync), .cfgHBack(cfgHBack), .cfgWidth(cfgWidth), .cfgHFront(cfgHFront),
    .cfgVSync(cfgVSync), .cfgVBack(cfgVBack), .cfgHeight(cfgHeight), .cfgVFront(cfgVFront),
    .cfgHSyncLow(cfgHSyncLow), .cfgVSyncLow(cfgVSyncLow), .cfgFmt(cfgFmt),
    .cfgDiv(cfgDiv), .cfgBypass(cfgBypass), .cfgClkFall(cfgClkFall),
    .pixStrobe(pixStrobe), .pclkOut(pclkOut), .hsync(hsync), .vsync(vsync), .de(de),
    .pixX(pixX), .pixY(pixY), .busMask(busMask)
  );

  int nTests = 0;
  int nFail  = 0;
  bit done   = 0;

  // expected-model state, taken from the fields at each frame start
  int eHs, eHb, eW, eHf, eVs, eVb, eHt, eVf, eN, eFmt, frameLen, kIdx;
  bit eHLow, eVLow, eBypass, eFall;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] maskOf(input int f);
    case (f)
      0: return 24'h000FFF;
      1: return 24'h00FFFF;
      2: return 24'h03FFFF;
      default: return 24'hFFFFFF;
    endcase
  endfunction

  task automatic loadExp();
    eHs = int'(cfgHSync) + 1;  eHb = int'(cfgHBack) + 1;
    eW  = int'(cfgWidth) + 1;  eHf = int'(cfgHFront) + 1;
    eVs = int'(cfgVSync) + 1;  eVb = int'(cfgVBack);
    eHt = int'(cfgHeight) + 1; eVf = int'(cfgVFront) + 1;
    eN  = int'(cfgDiv) + 2;    eFmt = int'(cfgFmt);
    eHLow = cfgHSyncLow; eVLow = cfgVSyncLow;
    eBypass = cfgBypass; eFall = cfgClkFall;
    frameLen = (eHs + eHb + eW + eHf) * (eVs + eVb + eHt + eVf);
  endtask

  // R5 R6 R7 R8 R9: compare the pixel shown at this strobe with the model
  task automatic checkPos();
    int lineLen, l, p, x, y;
    bit xA, vA, eDe, eH, eV;
    longint act, exp;
    lineLen = eHs + eHb + eW + eHf;
    l = kIdx / lineLen;
    p = kIdx % lineLen;
    xA = (p >= eHs + eHb) && (p < eHs + eHb + eW);
    vA = (l >= eVs + eVb) && (l < eVs + eVb + eHt);
    eDe = xA && vA;
    x = eDe ? p - eHs - eHb : 0;
    y = eDe ? l - eVs - eVb : 0;
    eH = (p < eHs) ^ eHLow;
    eV = (l < eVs) ^ eVLow;
    exp = {longint'(eH), longint'(eV), longint'(eDe)} << 32 | longint'(x) << 16 | longint'(y);
    exp = (longint'(eH) << 34) | (longint'(eV) << 33) | (longint'(eDe) << 32) |
          (longint'(x) << 16) | longint'(y);
    act = (longint'(hsync) << 34) | (longint'(vsync) << 33) | (longint'(de) << 32) |
          (longint'(pixX) << 16) | longint'(pixY);
    chk(act == exp, "R5/R6/R7/R8 position", act, exp);
    chk(busMask == maskOf(eFmt), "R9 bus mask", longint'(busMask), longint'(maskOf(eFmt)));
  endtask

  task automatic runStrobes(input int nStr);
    int got = 0, cyc = 0, gap = 0, highs = 0;
    bit first = 1;
    logic prevP;
    prevP = pclkOut;
    while (got < nStr && cyc < 20000) begin
      @(negedge clk);
      cyc++; gap++;
      if (pclkOut) highs++;
      if (pixStrobe) begin
        checkPos();
        if (eBypass) begin
          // R3
          chk((first || gap == 1) && pclkOut, "R3 bypass strobe", gap, 1);
        end else begin
          if (!first) begin
            chk(gap == eN, "R2 strobe spacing", gap, eN);
            chk(highs == (eN + 1) / 2, "R2 high time", highs, (eN + 1) / 2);
          end
          // R4
          if (eFall) chk(prevP && !pclkOut, "R4 falling-edge strobe", {prevP, pclkOut}, 2);
          else       chk(!prevP && pclkOut, "R4 rising-edge strobe", {prevP, pclkOut}, 1);
        end
        first = 0; gap = 0; highs = 0; got++;
        kIdx++;
        if (kIdx == frameLen) begin
          kIdx = 0;
          loadExp();
        end
      end
      prevP = pclkOut;
    end
    if (got < nStr) chk(0, "R2 strobes missing", got, nStr);
  endtask

  task automatic startRun();
    @(negedge clk);
    enable = 1'b1;
    loadExp();
    kIdx = 0;
  endtask

  task automatic stopRun();
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic setTiming(input int hs, hb, w, hf, vs, vb, ht, vf);
    cfgHSync = SYNC_W'(hs); cfgHBack = PORCH_W'(hb); cfgWidth  = ACT_W'(w);  cfgHFront = PORCH_W'(hf);
    cfgVSync = SYNC_W'(vs); cfgVBack = PORCH_W'(vb); cfgHeight = ACT_W'(ht); cfgVFront = PORCH_W'(vf);
  endtask

  initial begin
    #3000000;
    if (!done) begin
      nTests++; nFail++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; enable = 1'b0;
    setTiming(1, 0, 3, 1, 0, 1, 2, 0);
    cfgHSyncLow = 1'b1; cfgVSyncLow = 1'b1;
    cfgFmt = 2'd3; cfgDiv = 8'd1; cfgBypass = 1'b0; cfgClkFall = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R1 idle outputs, sync at inactive level (polarity bits set)
    chk(!pixStrobe && !pclkOut && !de, "R1 idle strobes", {pixStrobe, pclkOut, de}, 0);
    chk(hsync && vsync, "R1 idle sync level", {hsync, vsync}, 3);
    chk(pixX == 0 && pixY == 0, "R1 idle position", {pixX, pixY}, 0);

    // R9 format sweep while idle
    for (int f = 0; f < 4; f++) begin
      cfgFmt = 2'(f);
      @(negedge clk);
      @(negedge clk);
      chk(busMask == maskOf(f), "R9 format sweep", busMask, maskOf(f));
    end

    // config A: ratio 3, rising edge, active-high syncs
    cfgHSyncLow = 1'b0; cfgVSyncLow = 1'b0; cfgFmt = 2'd3;
    cfgDiv = 8'd1; cfgClkFall = 1'b0;
    startRun();
    runStrobes(2 * 54 + 5);
    stopRun();
    chk(!pixStrobe && !de && !hsync && !vsync, "R1 after disable", {pixStrobe, de, hsync, vsync}, 0);

    // config B: ratio 4, falling edge, active-low syncs
    cfgDiv = 8'd2; cfgClkFall = 1'b1; cfgHSyncLow = 1'b1; cfgVSyncLow = 1'b1; cfgFmt = 2'd1;
    startRun();
    runStrobes(54 + 10);
    stopRun();

    // config C: bypass, divider field set but ignored; zero vertical back porch
    setTiming(0, 1, 2, 0, 1, 0, 1, 1);
    cfgBypass = 1'b1; cfgDiv = 8'd5; cfgClkFall = 1'b0;
    cfgHSyncLow = 1'b0; cfgVSyncLow = 1'b1; cfgFmt = 2'd0;
    startRun();
    runStrobes(2 * 6 * 5 + 3);
    stopRun();

    // config D: R10 mid-frame rewrite, ratio 2 then 3
    setTiming(1, 0, 3, 1, 0, 1, 2, 0);
    cfgBypass = 1'b0; cfgDiv = 8'd0; cfgClkFall = 1'b0;
    cfgHSyncLow = 1'b0; cfgVSyncLow = 1'b0; cfgFmt = 2'd3;
    startRun();
    runStrobes(20);
    cfgWidth = ACT_W'(1); cfgHSyncLow = 1'b1; cfgDiv = 8'd1; cfgFmt = 2'd2;
    @(negedge clk);
    // R10 the rewrite must not show before the frame ends
    chk(busMask == 24'hFFFFFF, "R10 mask held mid-frame", busMask, 24'hFFFFFF);
    runStrobes(54 - 20 + 42 + 4);
    stopRun();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule